// File: doc/BRIEF.md
# Multi-mode bridge PWM generator

This block turns one PWM waveform into drive signals for four output pins, A to D, so that a single core can run a single-ended load, a half bridge or a full H-bridge in either direction. A 10-bit time base advances once per clock. Its upper 8 bits form a period timer and its lower 2 bits form a sub-count. The timer restarts whenever its upper part equals the period setting and the sub-count is at its last value. Each new period the core output goes active. It goes inactive again once the time base reaches the 10-bit duty word, which is an 8-bit high part joined to a 2-bit low part.

The duty word is staged on input ports and copied into a working register only at a period boundary, so a value written mid-period never produces a torn pulse. Enabling the block takes effect at the next boundary. An output controller then steers the core PWM onto the four pins by mode. It inserts a programmable dead band on rising edges in half-bridge mode and applies a per-pair polarity. All pins are registered, so each pin follows the internal state with one clock of latency.

Top module: `bridge_pwm`

## Requirements
- R1: The period spans (period+1)*4 clocks. The time base runs from 0 up to {period, 2'b11} and then returns to 0, and that return is the period boundary.
- R2: Mode 2'b00 (single) drives the PWM on A: active from the boundary until the time base equals the working duty. B, C and D stay inactive.
- R3: A new duty value presented mid-period has no effect on the pins until the next period boundary.
- R4: After enable rises, all pins stay inactive until the next period boundary. The first pulse is always a full one.
- R5: A working duty of zero never makes the PWM active. A working duty above {period, 2'b11} keeps it active for the whole period.
- R6: Mode 2'b01 (half bridge) drives the PWM on A and its complement on B, and the two are never active together. C and D stay inactive.
- R7: In half-bridge mode each rising edge of A and of B is delayed by dead_len clocks. A dead_len of 0 gives no delay.
- R8: Mode 2'b10 (forward) holds A active and drives the PWM on D, with B and C inactive. Mode 2'b11 (reverse) holds C active and drives the PWM on B, with A and D inactive.
- R9: pol_sel bit 1 set makes A and C active-low, and pol_sel bit 0 set makes B and D active-low. An inactive pin sits at the opposite level.
- R10: After reset, and from the second clock after enable is seen low, every pin is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; starts at the next period boundary |
| period | input | 8 | Period setting (upper part of the last time-base count) |
| duty_hi | input | 8 | Staged duty, high 8 bits |
| duty_lo | input | 2 | Staged duty, low 2 bits |
| mode | input | 2 | 00 single, 01 half bridge, 10 forward, 11 reverse |
| pol_sel | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| dead_len | input | 7 | Dead-band delay in clocks for half-bridge mode |
| pin_a | output | 1 | Output A |
| pin_b | output | 1 | Output B |
| pin_c | output | 1 | Output C |
| pin_d | output | 1 | Output D |

## Verification
The hardest case to reach is a staged duty that changes or a start request that arrives partway through a period. In either case the pins must keep the old behaviour until the boundary. The stimulus changes the duty and raises enable at clock counts that are not aligned to the 40-clock period. A reference model tracks the boundary by itself and predicts every pin on every cycle. Dead-band widths of 3 and 5 clocks are run against a duty whose high and low phases are both longer than the delay, so that every rising edge can be seen held back.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic [1:0] {
    BP_SINGLE = 2'b00,
    BP_HALF   = 2'b01,
    BP_FWD    = 2'b10,
    BP_REV    = 2'b11
  } bp_mode_e;

  // pin order in vectors: bit0=A, bit1=B, bit2=C, bit3=D
  function automatic logic [3:0] pin_invert(input logic [1:0] pol);
    return {pol[0], pol[1], pol[0], pol[1]};
  endfunction
endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int BASE_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  duty_hi,
  input  logic [FRAC_W-1:0] duty_lo,
  output logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] work_duty,
  output logic              running,
  output logic              period_end,
  output logic              pwm_base
);
  logic [CNT_W-1:0]  tmr_q;
  logic [FRAC_W-1:0] frac_q;
  logic [BASE_W-1:0] work_q;
  logic              run_q;

  function automatic logic duty_active(input logic [BASE_W-1:0] b,
                                       input logic [BASE_W-1:0] d);
    return b < d;
  endfunction

  assign base       = {tmr_q, frac_q};
  assign period_end = (tmr_q == period) && (frac_q == {FRAC_W{1'b1}});
  assign work_duty  = work_q;
  assign running    = run_q;
  assign pwm_base   = run_q && duty_active(base, work_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      frac_q <= '0;
      work_q <= '0;
      run_q  <= 1'b0;
    end else if (period_end) begin
      tmr_q  <= '0;
      frac_q <= '0;
      work_q <= {duty_hi, duty_lo};
      run_q  <= enable;
    end else begin
      frac_q <= frac_q + 1'b1;
      if (frac_q == {FRAC_W{1'b1}}) tmr_q <= tmr_q + 1'b1;
      if (!enable) run_q <= 1'b0;
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (base == '0));
  assert_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(work_duty));
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !running) |=> !running);
endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer
  import bpwm_pkg::*;
(
  input  bp_mode_e   mode,
  input  logic       running,
  input  logic       pwm_base,
  output logic [3:0] req
);
  always_comb begin
    req = '0;
    unique case (mode)
      BP_SINGLE: req[0] = pwm_base;
      BP_HALF: begin
        req[0] = pwm_base;
        req[1] = running && !pwm_base;
      end
      BP_FWD: begin
        req[0] = running;
        req[3] = pwm_base;
      end
      BP_REV: begin
        req[2] = running;
        req[1] = pwm_base;
      end
      default: req = '0;
    endcase
  end
endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [DB_W-1:0] db_len,
  output logic            act
);
  logic [DB_W-1:0] cnt_q;

  assign act = req && (cnt_q >= db_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!req)            cnt_q <= '0;
    else if (cnt_q < db_len)  cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && (db_len != '0)) |-> !act);
endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
  import bpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DB_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  duty_hi,
  input  logic [FRAC_W-1:0] duty_lo,
  input  logic [1:0]        mode,
  input  logic [1:0]        pol_sel,
  input  logic [DB_W-1:0]   dead_len,
  output logic              pin_a,
  output logic              pin_b,
  output logic              pin_c,
  output logic              pin_d
);
  localparam int BASE_W = CNT_W + FRAC_W;
  localparam int NPIN   = 4;

  logic [BASE_W-1:0] base, work_duty;
  logic              running, period_end, pwm_base;
  logic [NPIN-1:0]   req, act, act_q, pins;
  logic [DB_W-1:0]   db_eff;
  bp_mode_e          mode_e;

  assign mode_e = bp_mode_e'(mode);
  assign db_eff = (mode_e == BP_HALF) ? dead_len : '0;

  bpwm_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .base(base),
    .work_duty(work_duty), .running(running), .period_end(period_end),
    .pwm_base(pwm_base)
  );

  bpwm_steer u_steer (
    .mode(mode_e), .running(running), .pwm_base(pwm_base), .req(req)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_db
    bpwm_deadband #(.DB_W(DB_W)) u_db (
      .clk(clk), .rst_n(rst_n), .req(req[g]), .db_len(db_eff), .act(act[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act;
  end

  assign pins  = act_q ^ pin_invert(pol_sel);
  assign pin_a = pins[0];
  assign pin_b = pins[1];
  assign pin_c = pins[2];
  assign pin_d = pins[3];

  assert_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == BP_SINGLE) |-> (act_q[3:1] == '0));
  assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == BP_HALF) |-> !(act_q[0] && act_q[1]));
  assert_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == BP_FWD) |-> (!act_q[1] && !act_q[2]));
  assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |=> (act_q == '0));
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (work_duty == '0) |-> !pwm_base);
endmodule

// File: tb/sim_bridge_pwm.sv
module sim_bridge_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] period = '0, duty_hi = '0;
  logic [1:0] duty_lo = '0, mode = '0, pol_sel = '0;
  logic [6:0] dead_len = '0;
  logic       pin_a, pin_b, pin_c, pin_d;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_tag = "R10";

  typedef struct { logic [3:0] pins; string tag; } exp_t;
  exp_t sbq[$];

  // reference state
  int m_base = 0, m_duty = 0;
  bit m_run = 0;
  int m_cnt [4];

  always #4 clk = ~clk;  // 125 MHz

  bridge_pwm u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .mode(mode), .pol_sel(pol_sel),
    .dead_len(dead_len), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .pin_d(pin_d)
  );

  // model: predicts pins after each edge, pushes to the scoreboard
  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_duty = 0; m_run = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else begin
      bit pw;
      bit [3:0] r, a, inv;
      int dl, last;
      exp_t e;
      pw = m_run && (m_base < m_duty);
      case (mode)
        2'b00: r = {3'b000, pw};
        2'b01: r = {2'b00, m_run && !pw, pw};
        2'b10: r = {pw, 2'b00, m_run};
        default: r = {1'b0, m_run, pw, 1'b0};
      endcase
      dl = (mode == 2'b01) ? int'(dead_len) : 0;
      for (int i = 0; i < 4; i++) begin
        a[i] = r[i] && (m_cnt[i] >= dl);
        if (!r[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < dl) m_cnt[i]++;
      end
      inv = {pol_sel[0], pol_sel[1], pol_sel[0], pol_sel[1]};
      e.pins = a ^ inv;
      e.tag = cur_tag;
      sbq.push_back(e);
      last = int'(period) * 4 + 3;
      if (m_base == last) begin
        m_base = 0; m_duty = int'({duty_hi, duty_lo}); m_run = enable;
      end else begin
        m_base = (m_base + 1) % 1024;
        if (!enable) m_run = 0;
      end
    end
  end

  // monitor: compares away from the edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      logic [3:0] got;
      e = sbq.pop_front();
      got = {pin_d, pin_c, pin_b, pin_a};
      checks++;
      if (got !== e.pins) begin
        errors++;
        $display("FAIL %s: pins DCBA actual=%b expected=%b at %0t",
                 e.tag, got, e.pins, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_200_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    run(5);
    rst_n = 1'b1;
    // R10: reset state, all pins inactive (active-high)
    #1;
    checks++;
    if ({pin_d, pin_c, pin_b, pin_a} !== 4'b0000) begin
      errors++;
      $display("FAIL R10: reset pins actual=%b expected=0000",
               {pin_d, pin_c, pin_b, pin_a});
    end
    run(3);
    // R1 / R2: single mode, period 40 clocks, duty 22
    cur_tag = "R2"; period = 8'd9; duty_hi = 8'd5; duty_lo = 2'd2;
    mode = 2'b00; enable = 1'b1;
    run(13);
    cur_tag = "R1"; run(110);
    // R3: duty change mid-period
    cur_tag = "R3"; run(17); duty_hi = 8'd2; duty_lo = 2'd1; run(100);
    // R5: duty above last count, then zero
    cur_tag = "R5"; duty_hi = 8'd12; duty_lo = 2'd0; run(90);
    duty_hi = 8'd0; duty_lo = 2'd0; run(90);
    // R6: half bridge without dead band
    cur_tag = "R6"; mode = 2'b01; duty_hi = 8'd4; duty_lo = 2'd2; run(90);
    // R7: dead band 3 and 5
    cur_tag = "R7"; dead_len = 7'd3; run(90); dead_len = 7'd5; run(90);
    // R8: forward then reverse
    cur_tag = "R8"; dead_len = 7'd0; mode = 2'b10; duty_hi = 8'd6; run(90);
    mode = 2'b11; run(90);
    // R9: polarity combinations in half bridge with dead band
    cur_tag = "R9"; mode = 2'b01; dead_len = 7'd2;
    pol_sel = 2'b01; run(90); pol_sel = 2'b10; run(90);
    pol_sel = 2'b11; run(90);
    // R10: disable, pins go inactive
    cur_tag = "R10"; enable = 1'b0; run(60);
    // R4: enable raised mid-period, first output at boundary
    cur_tag = "R4"; mode = 2'b00; pol_sel = 2'b00; run(7);
    enable = 1'b1; run(100);
    @(posedge clk); #3;
    finish_run();
  end
endmodule